// File: doc/BRIEF.md
# Go-Back-N Retransmitting Link

This block carries a stream of flits across one switch-to-switch link whose wires are broken into a configurable number of register stages. The transmitting end writes every accepted flit into a replay buffer. It sends flits one after another without waiting for any response. Each flit leaves with a sequence tag and an 8-bit CRC.

The receiving end checks each arriving flit. For a good flit it returns an acknowledgement, and for a flit it cannot take it returns a negative acknowledgement. The response travels back over its own pipelined wires. A negative acknowledgement makes the transmitting end rewind to the rejected flit and replay everything from there. While the replay is on its way, the receiving end discards whatever else arrives.

The upstream side is a valid/ready stream. A flit moves when `in_valid` and `in_ready` are both high at a rising edge, and `in_ready` falls only because the replay window is full. The downstream side is valid/ready too. A flit is delivered when `out_valid` and `out_ready` are both high. `out_valid` is only an offer that lasts for one cycle. If the consumer is not ready, that flit is rejected and offered again later through the replay. `lnk_flip` is a plain fault input: its bits are XORed onto the forward link at the entry to the link pipeline.

Top module: `gbn_link`

## Requirements
- R1: After reset, `in_ready` is 1 and `out_valid` is 0.
- R2: With no errors and `out_ready` high, every accepted flit appears exactly once and in order on `out_data`. A flit accepted at an edge shows on `out_valid` STAGES+2 cycles after the cycle in which it was offered.
- R3: The replay window holds DEPTH = 2*STAGES + SW_LAT flits (SW_LAT defaults to 4). With the defaults, a continuous error-free stream is delivered one flit per cycle with no idle cycle between deliveries.
- R4: `in_ready` is low exactly when DEPTH flits are unacknowledged. If nothing is ever acknowledged, exactly DEPTH flits are accepted and `in_ready` then stays low.
- R5: The forward frame is {tag, data, crc}, with the tag in the upper bits and the crc in the lowest 8 bits. The crc is CRC-8 with polynomial x^8+x^2+x+1 and initial value zero, computed MSB first over {tag, data}. A flit whose crc does not match is never delivered and draws a negative acknowledgement. Any single-bit flip set on `lnk_flip` while a flit enters the link is therefore caught.
- R6: After a rejection, the receiver ignores the next 2*STAGES+1 link cycles. It judges the flit arriving 2*STAGES+2 cycles after the rejected one, which is the replayed flit. In a continuous stream this gives a gap of exactly 2*STAGES+2 idle cycles between deliveries.
- R7: On a negative acknowledgement, the sender resends from the rejected tag, which is always the oldest unacknowledged one, and continues in tag order. Outside a rewind, consecutive transmissions carry consecutive tags.
- R8: A flit offered while `out_ready` is low is rejected like a corrupted one and replayed later. No flit is lost or duplicated under any pattern of `out_ready` and link errors.
- R9: Each acknowledgement carries the tag of a delivered flit. On arrival it frees that flit and all older ones, and it always names a flit that is still outstanding.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Upstream flit offered |
| in_ready | output | 1 | Replay window has room |
| in_data | input | DW | Upstream flit payload |
| out_valid | output | 1 | Flit offered downstream this cycle |
| out_ready | input | 1 | Downstream takes the offered flit |
| out_data | output | DW | Delivered flit payload |
| lnk_flip | input | TW+DW+8 | Bits XORed onto the forward frame at link entry |

## Verification
Assertions inside the sender and receiver check these rules on every cycle: the window bound, tag ordering of transmissions, the fact that every negative acknowledgement names the oldest outstanding flit, that every acknowledgement names an outstanding one, and that every handshake or refusal at the output is followed by the matching response. The scoreboard bench is the only place that can show end-to-end properties: exact-once in-order delivery across errors and consumer stalls, the STAGES+2 latency, the gap-free stream, the replay gap of 2*STAGES+2 cycles, and the count of flits accepted before back-pressure.

// File: rtl/gbn_pkg.sv
package gbn_pkg;
  localparam int CRC_W = 8;

  // CRC-8, polynomial 0x07, zero seed, MSB first over the low nbits of msg
  function automatic logic [CRC_W-1:0] crc8(input logic [63:0] msg, input int nbits);
    logic [CRC_W-1:0] c;
    logic fb;
    c = '0;
    for (int i = 63; i >= 0; i--) begin
      if (i < nbits) begin
        fb = c[CRC_W-1] ^ msg[i];
        c  = {c[CRC_W-2:0], 1'b0};
        if (fb) c = c ^ 8'h07;
      end
    end
    return c;
  endfunction
endpackage

// File: rtl/gbn_stage_pipe.sv
module gbn_stage_pipe #(
  parameter int W      = 8,
  parameter int STAGES = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         src_v,
  input  logic [W-1:0] src_d,
  output logic         dst_v,
  output logic [W-1:0] dst_d
);
  logic         v_q [STAGES];
  logic [W-1:0] d_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_head
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          v_q[s] <= 1'b0;
          d_q[s] <= '0;
        end else begin
          v_q[s] <= src_v;
          d_q[s] <= src_d;
        end
      end
    end else begin : g_body
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          v_q[s] <= 1'b0;
          d_q[s] <= '0;
        end else begin
          v_q[s] <= v_q[s-1];
          d_q[s] <= d_q[s-1];
        end
      end
    end
  end

  assign dst_v = v_q[STAGES-1];
  assign dst_d = d_q[STAGES-1];
endmodule

// File: rtl/gbn_sender.sv
module gbn_sender
  import gbn_pkg::*;
#(
  parameter int DW    = 16,
  parameter int DEPTH = 10,
  parameter int AW    = 4,
  parameter int TW    = 5
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  output logic                  in_ready,
  input  logic [DW-1:0]         in_data,
  output logic                  tx_v,
  output logic [TW+DW+CRC_W-1:0] tx_frame,
  input  logic                  rsp_v,
  input  logic                  rsp_nack,
  input  logic [TW-1:0]         rsp_tag
);
  localparam int BUF = 1 << AW;

  logic [DW-1:0] mem [BUF];
  logic [TW-1:0] base_q, wr_q, nxt_q, tag_q;
  logic [DW-1:0] data_q;
  logic          v_q;
  logic [TW-1:0] used;
  logic          take;

  assign used     = wr_q - base_q;
  assign in_ready = used < TW'(DEPTH);
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (take) mem[wr_q[AW-1:0]] <= in_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      wr_q   <= '0;
      nxt_q  <= '0;
      tag_q  <= '0;
      data_q <= '0;
      v_q    <= 1'b0;
    end else begin
      if (take) wr_q <= wr_q + 1'b1;
      if (rsp_v && !rsp_nack) base_q <= rsp_tag + 1'b1;
      if (rsp_v && rsp_nack) begin
        v_q    <= 1'b1;
        tag_q  <= rsp_tag;
        data_q <= mem[rsp_tag[AW-1:0]];
        nxt_q  <= rsp_tag + 1'b1;
      end else if (nxt_q != wr_q) begin
        v_q    <= 1'b1;
        tag_q  <= nxt_q;
        data_q <= mem[nxt_q[AW-1:0]];
        nxt_q  <= nxt_q + 1'b1;
      end else begin
        v_q <= 1'b0;
      end
    end
  end

  assign tx_v     = v_q;
  assign tx_frame = {tag_q, data_q, crc8(64'({tag_q, data_q}), TW + DW)};

  // R4: never more than DEPTH flits held unacknowledged
  p_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
    used <= TW'(DEPTH));
  // R7: a rewind always targets the oldest unacknowledged flit
  p_nack_base_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_v && rsp_nack) |-> (rsp_tag == base_q));
  // R7: back-to-back transmissions step the tag unless a rewind intervened
  p_seq_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_v && $past(tx_v) && !$past(rsp_v && rsp_nack)) |-> (tag_q == $past(tag_q) + 1'b1));
  // R9: every acknowledgement names an outstanding flit
  p_ack_known_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_v && !rsp_nack) |-> (TW'(rsp_tag - base_q) < used));
endmodule

// File: rtl/gbn_receiver.sv
module gbn_receiver
  import gbn_pkg::*;
#(
  parameter int DW     = 16,
  parameter int TW     = 5,
  parameter int STAGES = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   lk_v,
  input  logic [TW+DW+CRC_W-1:0] lk_frame,
  output logic                   out_valid,
  input  logic                   out_ready,
  output logic [DW-1:0]          out_data,
  output logic                   rsp_v,
  output logic                   rsp_nack,
  output logic [TW-1:0]          rsp_tag
);
  localparam int SLOT = 2 * STAGES + 2;
  localparam int CW   = $clog2(SLOT + 1);

  logic [TW-1:0]    f_tag;
  logic [DW-1:0]    f_data;
  logic [CRC_W-1:0] f_crc;
  logic             crc_ok, at_slot, judge, fit;
  logic             drop_q;
  logic [CW-1:0]    cnt_q;
  logic [TW-1:0]    exp_q;

  assign f_tag   = lk_frame[TW+DW+CRC_W-1 -: TW];
  assign f_data  = lk_frame[CRC_W +: DW];
  assign f_crc   = lk_frame[CRC_W-1:0];
  assign crc_ok  = crc8(64'({f_tag, f_data}), TW + DW) == f_crc;
  assign at_slot = drop_q && (cnt_q == CW'(SLOT));
  assign judge   = (!drop_q && lk_v) || at_slot;
  assign fit     = lk_v && crc_ok && (f_tag == exp_q);

  assign out_valid = judge && fit;
  assign out_data  = f_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      drop_q   <= 1'b0;
      cnt_q    <= '0;
      exp_q    <= '0;
      rsp_v    <= 1'b0;
      rsp_nack <= 1'b0;
      rsp_tag  <= '0;
    end else begin
      rsp_v <= 1'b0;
      if (drop_q && !at_slot) cnt_q <= cnt_q + 1'b1;
      if (judge) begin
        rsp_v   <= 1'b1;
        rsp_tag <= exp_q;
        if (fit && out_ready) begin
          rsp_nack <= 1'b0;
          exp_q    <= exp_q + 1'b1;
          drop_q   <= 1'b0;
        end else begin
          rsp_nack <= 1'b1;
          drop_q   <= 1'b1;
          cnt_q    <= CW'(1);
        end
      end
    end
  end

  // R2: a completed handshake is acknowledged with its own tag next cycle
  p_ack_deliver_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready) |=> (rsp_v && !rsp_nack && rsp_tag == $past(exp_q)));
  // R8: a refused offer turns into a negative acknowledgement
  p_refuse_nack_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (rsp_v && rsp_nack));
  // R5: a frame with a bad checksum never reaches the output
  p_bad_hidden_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_v && !crc_ok) |-> !out_valid);
endmodule

// File: rtl/gbn_link.sv
module gbn_link
  import gbn_pkg::*;
#(
  parameter int DW     = 16,
  parameter int STAGES = 3,
  parameter int SW_LAT = 4,
  localparam int DEPTH = 2 * STAGES + SW_LAT,
  localparam int AW    = $clog2(DEPTH),
  localparam int TW    = AW + 1,
  localparam int FW    = TW + DW + CRC_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_data,
  input  logic [FW-1:0] lnk_flip
);
  logic          tx_v, lk_v;
  logic [FW-1:0] tx_frame, lk_frame;
  logic          rsp_v, rsp_nack, bk_v;
  logic [TW-1:0] rsp_tag;
  logic [TW:0]   bk_d;

  gbn_sender #(.DW(DW), .DEPTH(DEPTH), .AW(AW), .TW(TW)) u_tx (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .tx_v(tx_v), .tx_frame(tx_frame),
    .rsp_v(bk_v), .rsp_nack(bk_d[TW]), .rsp_tag(bk_d[TW-1:0])
  );

  gbn_stage_pipe #(.W(FW), .STAGES(STAGES)) u_fwd (
    .clk(clk), .rst_n(rst_n),
    .src_v(tx_v), .src_d(tx_frame ^ lnk_flip),
    .dst_v(lk_v), .dst_d(lk_frame)
  );

  gbn_receiver #(.DW(DW), .TW(TW), .STAGES(STAGES)) u_rx (
    .clk(clk), .rst_n(rst_n),
    .lk_v(lk_v), .lk_frame(lk_frame),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .rsp_v(rsp_v), .rsp_nack(rsp_nack), .rsp_tag(rsp_tag)
  );

  gbn_stage_pipe #(.W(TW + 1), .STAGES(STAGES)) u_bwd (
    .clk(clk), .rst_n(rst_n),
    .src_v(rsp_v), .src_d({rsp_nack, rsp_tag}),
    .dst_v(bk_v), .dst_d(bk_d)
  );
endmodule

// File: tb/sim_gbn_link.sv
`timescale 1ns/1ps
module sim_gbn_link;
  localparam int DW = 16, N = 3, M = 4;
  localparam int D  = 2 * N + M;
  localparam int TW = $clog2(D) + 1;
  localparam int FW = TW + DW + 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, out_ready = 1'b1;
  logic [DW-1:0] in_data = '0;
  logic [FW-1:0] lnk_flip = '0;
  logic in_ready, out_valid;
  logic [DW-1:0] out_data;

  gbn_link #(.DW(DW), .STAGES(N), .SW_LAT(M)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .lnk_flip(lnk_flip)
  );

  always #4 clk = ~clk;

  int cyc = 0, n_pass = 0, n_fail = 0;
  int pushed = 0, delivered = 0, last_cyc = 0, max_gap = 0;
  bit seen = 0;
  string cur_req = "R2";
  logic [DW-1:0] sb[$];
  logic [DW-1:0] seed = 16'h1000;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    if (ok) n_pass++;
    else begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // monitor: pops the scoreboard on every handshake
  always begin
    @(negedge clk);
    #1;
    if (rst_n && out_valid && out_ready) begin
      if (sb.size() == 0) check(0, cur_req, "delivery with empty scoreboard", int'(out_data), -1);
      else begin
        logic [DW-1:0] e;
        e = sb.pop_front();
        check(out_data == e, cur_req, "delivered data", int'(out_data), int'(e));
      end
      delivered++;
      if (seen && (cyc - last_cyc - 1) > max_gap) max_gap = cyc - last_cyc - 1;
      seen = 1;
      last_cyc = cyc;
    end
  end

  task automatic push_n(input int n);
    int sent = 0;
    while (sent < n) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_data  = seed;
      if (in_ready) begin
        sb.push_back(seed);
        seed++;
        sent++;
        pushed++;
      end
    end
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic drain();
    int k = 0;
    while (sb.size() != 0 && k < 3000) begin
      @(negedge clk);
      k++;
    end
    repeat (2 * N + 8) @(negedge clk);
  endtask

  always @(posedge clk) begin
    if (cyc > 100000) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d expected below 100000 cycles", cyc);
      $display("%0d/%0d checks passed", n_pass, n_pass + n_fail);
      $finish;
    end
  end

  initial begin
    int lat;
    int acc;
    repeat (3) @(negedge clk);
    check(in_ready == 1'b1, "R1", "in_ready after reset", int'(in_ready), 1);
    check(out_valid == 1'b0, "R1", "out_valid after reset", int'(out_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2: single flit latency
    cur_req = "R2";
    in_valid = 1'b1;
    in_data = seed;
    sb.push_back(seed);
    seed++;
    pushed++;
    @(negedge clk);
    in_valid = 1'b0;
    lat = 1;
    while (!out_valid && lat < 40) begin
      @(negedge clk);
      lat++;
    end
    check(lat == N + 2, "R2", "offer-to-output latency", lat, N + 2);
    drain();

    // R3: continuous error-free stream
    cur_req = "R3";
    seen = 0;
    max_gap = 0;
    acc = delivered;
    push_n(60);
    drain();
    check(delivered - acc == 60, "R3", "flits delivered in stream", delivered - acc, 60);
    check(max_gap == 0, "R3", "idle cycles inside stream", max_gap, 0);

    // R5 R6 R7: one corrupted flit in a continuous stream
    cur_req = "R5";
    seen = 0;
    max_gap = 0;
    acc = delivered;
    fork
      push_n(60);
      begin
        repeat (25) @(negedge clk);
        lnk_flip = FW'(1) << 12;
        @(negedge clk);
        lnk_flip = '0;
      end
    join
    drain();
    check(delivered - acc == 60, "R7", "flits delivered after rewind", delivered - acc, 60);
    check(max_gap == 2 * N + 2, "R6", "replay gap", max_gap, 2 * N + 2);

    // R4: consumer refuses everything, window fills
    cur_req = "R4";
    out_ready = 1'b0;
    acc = 0;
    repeat (40) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_data = seed;
      if (in_ready) begin
        sb.push_back(seed);
        seed++;
        pushed++;
        acc++;
      end
    end
    @(negedge clk);
    in_valid = 1'b0;
    check(acc == D, "R4", "flits accepted with no acks", acc, D);
    check(in_ready == 1'b0, "R4", "in_ready with full window", int'(in_ready), 0);
    repeat (20) @(negedge clk);
    check(in_ready == 1'b0, "R4", "in_ready still low", int'(in_ready), 0);
    check(sb.size() == D, "R8", "nothing delivered while refused", sb.size(), D);
    cur_req = "R8";
    out_ready = 1'b1;
    drain();
    check(sb.size() == 0, "R8", "refused flits replayed", sb.size(), 0);

    // R8 R5: random consumer stalls and random single-bit link errors
    cur_req = "R8";
    fork
      push_n(120);
      begin
        repeat (400) begin
          @(negedge clk);
          out_ready = ($urandom % 4) != 0;
          lnk_flip = (($urandom % 16) == 0) ? (FW'(1) << ($urandom % FW)) : '0;
        end
        @(negedge clk);
        out_ready = 1'b1;
        lnk_flip = '0;
      end
    join
    drain();
    check(sb.size() == 0, "R8", "scoreboard empty after random run", sb.size(), 0);
    check(delivered == pushed, "R2", "total delivered equals accepted", delivered, pushed);
    check(in_ready == 1'b1, "R9", "window released by acks", int'(in_ready), 1);

    $display("%0d/%0d checks passed", n_pass, n_pass + n_fail);
    $finish;
  end
endmodule